// File: doc/BRIEF.md
# Real-Mode Physical Address Generator

This block turns a segmented 16-bit address request into a physical memory address. A request names an access class (data, code fetch or stack), an address form that picks which base and index registers take part, a displacement size and value, a string-operation flag and an optional segment override. The block takes the current register values as inputs. It picks the effective segment, adds the offset terms with 16-bit wrap, shifts the segment left by four and adds it to the offset. Bit 20 of the result is gated by a wrap-enable input, which reproduces the wrap at 1 MB that older machines show.

The result is registered. A small two-state controller drives the valid strobe. `ST_IDLE` is the reset state and means no result is being presented. `ST_EMIT` means a fresh address is on the output in this cycle. The transition `IDLE->EMIT` and the transition `EMIT->EMIT` are both taken on a cycle with a request. The transition `EMIT->IDLE` and the transition `IDLE->IDLE` are both taken on a cycle without one. The address register loads only on request cycles and otherwise holds its last value.

Top module: `rmag_addr_gen`

## Requirements
- R1: While reset is low and after it is released, before any request, `valid_o` is 0 and `paddr_o` is 0.
- R2: A request at a clock edge makes `valid_o` high in the cycle after it, for one cycle for each request. Back-to-back requests each produce a valid cycle. Without a request, `valid_o` is 0 and `paddr_o` keeps its last value.
- R3: The physical address is the segment value times 16 plus the 16-bit offset. For example, segment 123Ah with offset 341Bh gives 157BBh.
- R4: The offset is the sum of the base, index and displacement terms, wrapped to 16 bits before the segment is added. The `form_i` code selects the terms: 0 is displacement only, 1 is BX, 2 is BP, 3 is SI, 4 is DI, 5 is BX+SI, 6 is BX+DI, 7 is BP+SI and 8 is BP+DI. Codes 9 to 15 act as displacement only.
- R5: The displacement size code `disp_size_i` works as follows: 0 adds no displacement, 1 adds `disp_i[7:0]` sign-extended to 16 bits, and 2 or 3 adds all 16 bits. When the size is 1, `disp_i[15:8]` has no effect.
- R6: For a data access with no override, any form that uses BP (codes 2, 7 and 8) selects SS.
- R7: For a data access with form code 4 and `string_op_i` high, ES is selected and the override input has no effect.
- R8: For a data access with no override, every other form selects DS.
- R9: For a data access with `ovr_en_i` high (and outside R7), the segment named by `ovr_seg_i` is used: 0 is ES, 1 is CS, 2 is SS and 3 is DS.
- R10: The `acc_class_i` code works as follows: 0 or 3 is data, 1 is code fetch and 2 is stack. A code fetch uses CS with the instruction pointer, and a stack access uses SS with the stack pointer. For both, the form, displacement, string flag and override have no effect.
- R11: With `a20_en_i` high, segment FFFFh and offset FFFFh give 10FFEFh, and segment FFFFh with offset 0010h gives 100000h. With `a20_en_i` low, bit 20 is 0, so FFFFh:FFFFh gives 0FFEFh. Bits 23 to 21 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe; the inputs are captured on this edge |
| acc_class_i | input | 2 | Access class: 0/3 data, 1 code fetch, 2 stack |
| form_i | input | 4 | Address form code (see R4) |
| disp_size_i | input | 2 | Displacement size: 0 none, 1 byte, 2/3 word |
| string_op_i | input | 1 | The access is the DI side of a string operation |
| ovr_en_i | input | 1 | Segment override enable |
| ovr_seg_i | input | 2 | Override segment: 0 ES, 1 CS, 2 SS, 3 DS |
| disp_i | input | 16 | Displacement value |
| bx_i | input | 16 | BX register value |
| bp_i | input | 16 | BP register value |
| si_i | input | 16 | SI register value |
| di_i | input | 16 | DI register value |
| ip_i | input | 16 | Instruction pointer value |
| sp_i | input | 16 | Stack pointer value |
| es_i | input | 16 | ES segment value |
| cs_i | input | 16 | CS segment value |
| ss_i | input | 16 | SS segment value |
| ds_i | input | 16 | DS segment value |
| a20_en_i | input | 1 | High lets bit 20 through; low forces it to 0 |
| paddr_o | output | 24 | Registered physical address |
| valid_o | output | 1 | High for one cycle after each request |

## Verification
The in-RTL properties check the following on every cycle: the request-to-valid timing, that the address holds between requests, the bit-20 gate, that the top bits are zero, and the full code-fetch and stack sums against the captured register values. The choice of default segment for each addressing form, how string-DI and the override interact, sign extension of a byte displacement, and 16-bit wrap of the offset are shown only by the bench's vectors. Those vectors use fixed register values chosen so that each segment gives a distinct base.

// File: rtl/rmag_pkg.sv
package rmag_pkg;

    localparam int WORD_W    = 16;
    localparam int SEG_SHIFT = 4;
    localparam int BYTE_W    = 8;
    localparam int SUM_W     = WORD_W + SEG_SHIFT + 1;

    typedef enum logic [1:0] {
        ACC_DATA  = 2'd0,
        ACC_CODE  = 2'd1,
        ACC_STACK = 2'd2,
        ACC_DATA2 = 2'd3
    } acc_class_e;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_id_e;

    typedef enum logic [3:0] {
        FORM_DISP  = 4'd0,
        FORM_BX    = 4'd1,
        FORM_BP    = 4'd2,
        FORM_SI    = 4'd3,
        FORM_DI    = 4'd4,
        FORM_BX_SI = 4'd5,
        FORM_BX_DI = 4'd6,
        FORM_BP_SI = 4'd7,
        FORM_BP_DI = 4'd8
    } addr_form_e;

    typedef enum logic [1:0] {
        DSZ_NONE  = 2'd0,
        DSZ_BYTE  = 2'd1,
        DSZ_WORD  = 2'd2,
        DSZ_WORD2 = 2'd3
    } disp_size_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } gen_state_e;

endpackage

// File: rtl/rmag_seg_select.sv
module rmag_seg_select
    import rmag_pkg::*;
#(
    parameter int SEG_W = WORD_W
) (
    input  logic [1:0]       acc_class_i,
    input  logic [3:0]       form_i,
    input  logic             string_op_i,
    input  logic             ovr_en_i,
    input  logic [1:0]       ovr_seg_i,
    input  logic [SEG_W-1:0] es_i,
    input  logic [SEG_W-1:0] cs_i,
    input  logic [SEG_W-1:0] ss_i,
    input  logic [SEG_W-1:0] ds_i,
    output logic [SEG_W-1:0] seg_o
);

    logic    uses_bp;
    logic    string_dest;
    seg_id_e pick;

    always_comb begin
        case (form_i)
            FORM_BP, FORM_BP_SI, FORM_BP_DI: uses_bp = 1'b1;
            default:                         uses_bp = 1'b0;
        endcase
    end

    assign string_dest = string_op_i && (form_i == FORM_DI);

    // Priority: the access class, then the string destination, then the override, then the default for the form
    always_comb begin
        case (acc_class_i)
            ACC_CODE:  pick = SEG_CS;
            ACC_STACK: pick = SEG_SS;
            default: begin
                if (string_dest)
                    pick = SEG_ES;
                else if (ovr_en_i)
                    pick = seg_id_e'(ovr_seg_i);
                else if (uses_bp)
                    pick = SEG_SS;
                else
                    pick = SEG_DS;
            end
        endcase
    end

    always_comb begin
        unique case (pick)
            SEG_ES: seg_o = es_i;
            SEG_CS: seg_o = cs_i;
            SEG_SS: seg_o = ss_i;
            SEG_DS: seg_o = ds_i;
        endcase
    end

endmodule

// File: rtl/rmag_offset_calc.sv
module rmag_offset_calc
    import rmag_pkg::*;
#(
    parameter int OFS_W     = WORD_W,
    parameter int SHORT_W   = BYTE_W,
    parameter bit SIGN_EXT  = 1'b1
) (
    input  logic [1:0]       acc_class_i,
    input  logic [3:0]       form_i,
    input  logic [1:0]       disp_size_i,
    input  logic [OFS_W-1:0] disp_i,
    input  logic [OFS_W-1:0] bx_i,
    input  logic [OFS_W-1:0] bp_i,
    input  logic [OFS_W-1:0] si_i,
    input  logic [OFS_W-1:0] di_i,
    input  logic [OFS_W-1:0] ip_i,
    input  logic [OFS_W-1:0] sp_i,
    output logic [OFS_W-1:0] ofs_o
);

    localparam int EXT_W = OFS_W - SHORT_W;

    logic [OFS_W-1:0] base_term;
    logic [OFS_W-1:0] index_term;
    logic [OFS_W-1:0] short_disp;
    logic [OFS_W-1:0] disp_term;

    generate
        if (SIGN_EXT) begin : g_sext
            assign short_disp = {{EXT_W{disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};
        end else begin : g_zext
            assign short_disp = {{EXT_W{1'b0}}, disp_i[SHORT_W-1:0]};
        end
    endgenerate

    always_comb begin
        base_term  = '0;
        index_term = '0;
        case (form_i)
            FORM_BX:    base_term = bx_i;
            FORM_BP:    base_term = bp_i;
            FORM_SI:    index_term = si_i;
            FORM_DI:    index_term = di_i;
            FORM_BX_SI: begin base_term = bx_i; index_term = si_i; end
            FORM_BX_DI: begin base_term = bx_i; index_term = di_i; end
            FORM_BP_SI: begin base_term = bp_i; index_term = si_i; end
            FORM_BP_DI: begin base_term = bp_i; index_term = di_i; end
            default: ;
        endcase
    end

    always_comb begin
        unique case (disp_size_e'(disp_size_i))
            DSZ_NONE:            disp_term = '0;
            DSZ_BYTE:            disp_term = short_disp;
            DSZ_WORD, DSZ_WORD2: disp_term = disp_i;
        endcase
    end

    // The sum is held to OFS_W bits, so any carry out of the offset is dropped
    always_comb begin
        case (acc_class_i)
            ACC_CODE:  ofs_o = ip_i;
            ACC_STACK: ofs_o = sp_i;
            default:   ofs_o = base_term + index_term + disp_term;
        endcase
    end

endmodule

// File: rtl/rmag_phys_compose.sv
module rmag_phys_compose
    import rmag_pkg::*;
#(
    parameter int SEG_W  = WORD_W,
    parameter int SHIFT  = SEG_SHIFT,
    parameter int ADDR_W = 24
) (
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [SEG_W-1:0]  ofs_i,
    input  logic              a20_en_i,
    output logic [ADDR_W-1:0] paddr_o
);

    localparam int RAW_W    = SEG_W + SHIFT + 1;
    localparam int WRAP_BIT = SEG_W + SHIFT;

    logic [RAW_W-1:0] raw_sum;
    logic [RAW_W-1:0] gated;

    assign raw_sum = {1'b0, seg_i, {SHIFT{1'b0}}} + {{(SHIFT+1){1'b0}}, ofs_i};

    always_comb begin
        gated           = raw_sum;
        gated[WRAP_BIT] = raw_sum[WRAP_BIT] & a20_en_i;
    end

    generate
        if (ADDR_W > RAW_W) begin : g_pad
            assign paddr_o = {{(ADDR_W-RAW_W){1'b0}}, gated};
        end else begin : g_trim
            assign paddr_o = gated[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/rmag_addr_gen.sv
module rmag_addr_gen
    import rmag_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [1:0]        acc_class_i,
    input  logic [3:0]        form_i,
    input  logic [1:0]        disp_size_i,
    input  logic              string_op_i,
    input  logic              ovr_en_i,
    input  logic [1:0]        ovr_seg_i,
    input  logic [15:0]       disp_i,
    input  logic [15:0]       bx_i,
    input  logic [15:0]       bp_i,
    input  logic [15:0]       si_i,
    input  logic [15:0]       di_i,
    input  logic [15:0]       ip_i,
    input  logic [15:0]       sp_i,
    input  logic [15:0]       es_i,
    input  logic [15:0]       cs_i,
    input  logic [15:0]       ss_i,
    input  logic [15:0]       ds_i,
    input  logic              a20_en_i,
    output logic [ADDR_W-1:0] paddr_o,
    output logic              valid_o
);

    localparam int WRAP_BIT = WORD_W + SEG_SHIFT;

    gen_state_e        state_q, state_d;
    logic [WORD_W-1:0] seg_w;
    logic [WORD_W-1:0] ofs_w;
    logic [ADDR_W-1:0] paddr_w;
    logic [ADDR_W-1:0] paddr_q;

    rmag_seg_select #(.SEG_W(WORD_W)) u_seg (
        .acc_class_i (acc_class_i),
        .form_i      (form_i),
        .string_op_i (string_op_i),
        .ovr_en_i    (ovr_en_i),
        .ovr_seg_i   (ovr_seg_i),
        .es_i        (es_i),
        .cs_i        (cs_i),
        .ss_i        (ss_i),
        .ds_i        (ds_i),
        .seg_o       (seg_w)
    );

    rmag_offset_calc #(.OFS_W(WORD_W), .SHORT_W(BYTE_W), .SIGN_EXT(1'b1)) u_ofs (
        .acc_class_i (acc_class_i),
        .form_i      (form_i),
        .disp_size_i (disp_size_i),
        .disp_i      (disp_i),
        .bx_i        (bx_i),
        .bp_i        (bp_i),
        .si_i        (si_i),
        .di_i        (di_i),
        .ip_i        (ip_i),
        .sp_i        (sp_i),
        .ofs_o       (ofs_w)
    );

    rmag_phys_compose #(.SEG_W(WORD_W), .SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)) u_comp (
        .seg_i    (seg_w),
        .ofs_i    (ofs_w),
        .a20_en_i (a20_en_i),
        .paddr_o  (paddr_w)
    );

    // Next-state logic: IDLE->EMIT and EMIT->EMIT on a request, otherwise back to IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_i ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = req_i ? ST_EMIT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            paddr_q <= '0;
        else if (req_i)
            paddr_q <= paddr_w;
    end

    assign paddr_o = paddr_q;
    assign valid_o = (state_q == ST_EMIT);

    // R2
    req_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);

    // R2
    idle_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);

    // R2
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(paddr_o));

    // R11
    wrap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !a20_en_i) |=> !paddr_o[WRAP_BIT]);

    // R11
    high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        paddr_o[ADDR_W-1:WRAP_BIT+1] == '0);

    // R10
    code_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && a20_en_i && acc_class_i == ACC_CODE) |=>
        paddr_o == ADDR_W'({1'b0, $past(cs_i), 4'h0} + {5'h00, $past(ip_i)}));

    // R10
    stack_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && a20_en_i && acc_class_i == ACC_STACK) |=>
        paddr_o == ADDR_W'({1'b0, $past(ss_i), 4'h0} + {5'h00, $past(sp_i)}));

endmodule

// File: tb/rmag_addr_gen_test.sv
module rmag_addr_gen_test;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  acc;
        logic [3:0]  form;
        logic [1:0]  dsz;
        logic        str;
        logic        oen;
        logic [1:0]  oseg;
        logic [15:0] disp;
        logic [23:0] exp;
        logic [7:0]  tag;
    } vec_t;

    // Fixed registers: BX 1000 BP 0200 SI 0030 DI 0004 IP 0100 SP FFFE; ES 3000 CS F000 SS 2000 DS 1000
    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 4'd0, 2'd2, 1'b0, 1'b0, 2'd0, 16'h1234, 24'h011234, 8'd8},  // R8 disp only
        '{2'd0, 4'd1, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0000, 24'h011000, 8'd8},  // R8 BX
        '{2'd0, 4'd2, 2'd1, 1'b0, 1'b0, 2'd0, 16'h00FF, 24'h0201FF, 8'd6},  // R6 BP-1
        '{2'd0, 4'd7, 2'd2, 1'b0, 1'b0, 2'd0, 16'h0010, 24'h020240, 8'd6},  // R6 BP+SI+d
        '{2'd0, 4'd4, 2'd0, 1'b1, 1'b0, 2'd0, 16'h0000, 24'h030004, 8'd7},  // R7 string DI
        '{2'd0, 4'd4, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0000, 24'h010004, 8'd8},  // R8 DI plain
        '{2'd0, 4'd4, 2'd0, 1'b1, 1'b1, 2'd1, 16'h0000, 24'h030004, 8'd7},  // R7 override ignored
        '{2'd0, 4'd5, 2'd1, 1'b0, 1'b1, 2'd0, 16'h0005, 24'h031035, 8'd9},  // R9 ES override
        '{2'd0, 4'd8, 2'd0, 1'b0, 1'b1, 2'd3, 16'h0000, 24'h010204, 8'd9},  // R9 DS over BP
        '{2'd0, 4'd1, 2'd0, 1'b0, 1'b1, 2'd2, 16'h0000, 24'h021000, 8'd9},  // R9 SS over BX
        '{2'd1, 4'd5, 2'd2, 1'b0, 1'b1, 2'd0, 16'h5555, 24'h0F0100, 8'd10}, // R10 code
        '{2'd2, 4'd2, 2'd2, 1'b0, 1'b1, 2'd1, 16'h1111, 24'h02FFFE, 8'd10}, // R10 stack
        '{2'd0, 4'd6, 2'd2, 1'b0, 1'b0, 2'd0, 16'hF000, 24'h010004, 8'd4},  // R4 wrap
        '{2'd0, 4'd3, 2'd1, 1'b0, 1'b0, 2'd0, 16'h1280, 24'h01FFB0, 8'd5},  // R5 -128, hi byte ignored
        '{2'd0, 4'd9, 2'd2, 1'b0, 1'b0, 2'd0, 16'h0010, 24'h010010, 8'd4}   // R4 unused code
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [1:0]  acc_class_i = '0;
    logic [3:0]  form_i = '0;
    logic [1:0]  disp_size_i = '0;
    logic        string_op_i = 1'b0;
    logic        ovr_en_i = 1'b0;
    logic [1:0]  ovr_seg_i = '0;
    logic [15:0] disp_i = '0;
    logic [15:0] bx_i = 16'h1000, bp_i = 16'h0200, si_i = 16'h0030, di_i = 16'h0004;
    logic [15:0] ip_i = 16'h0100, sp_i = 16'hFFFE;
    logic [15:0] es_i = 16'h3000, cs_i = 16'hF000, ss_i = 16'h2000, ds_i = 16'h1000;
    logic        a20_en_i = 1'b1;
    logic [23:0] paddr_o;
    logic        valid_o;

    int checks = 0;
    int failures = 0;

    rmag_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .acc_class_i(acc_class_i),
        .form_i(form_i), .disp_size_i(disp_size_i), .string_op_i(string_op_i),
        .ovr_en_i(ovr_en_i), .ovr_seg_i(ovr_seg_i), .disp_i(disp_i),
        .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i), .ip_i(ip_i), .sp_i(sp_i),
        .es_i(es_i), .cs_i(cs_i), .ss_i(ss_i), .ds_i(ds_i), .a20_en_i(a20_en_i),
        .paddr_o(paddr_o), .valid_o(valid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, capture at the rising edge, sample at the next falling edge
    task automatic issue(input logic [1:0] acc, input logic [3:0] form, input logic [1:0] dsz,
                         input logic str, input logic oen, input logic [1:0] oseg,
                         input logic [15:0] disp);
        @(negedge clk);
        acc_class_i = acc; form_i = form; disp_size_i = dsz;
        string_op_i = str; ovr_en_i = oen; ovr_seg_i = oseg; disp_i = disp;
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 valid in reset", {23'd0, valid_o}, 24'd0);
        check("R1 addr in reset", paddr_o, 24'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 valid after reset", {23'd0, valid_o}, 24'd0);
        check("R1 addr after reset", paddr_o, 24'd0);

        for (int i = 0; i < NVEC; i++) begin
            issue(VECS[i].acc, VECS[i].form, VECS[i].dsz, VECS[i].str,
                  VECS[i].oen, VECS[i].oseg, VECS[i].disp);
            check($sformatf("R%0d vector %0d addr", VECS[i].tag, i), paddr_o, VECS[i].exp);
            check($sformatf("R2 vector %0d valid", i), {23'd0, valid_o}, 24'd1);
        end

        // R2 hold and drop of valid with no request
        @(negedge clk);
        check("R2 valid drops", {23'd0, valid_o}, 24'd0);
        check("R2 addr held", paddr_o, 24'h010010);

        // R3 worked example 123A:341B
        ds_i = 16'h123A; bx_i = 16'h341B;
        issue(2'd0, 4'd1, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0000);
        check("R3 123A:341B", paddr_o, 24'h0157BB);

        // R2 back-to-back requests
        ds_i = 16'h1000; bx_i = 16'h1000;
        @(negedge clk);
        acc_class_i = 2'd0; form_i = 4'd1; disp_size_i = 2'd0;
        string_op_i = 1'b0; ovr_en_i = 1'b0; req_i = 1'b1;
        @(negedge clk);
        check("R2 first of pair valid", {23'd0, valid_o}, 24'd1);
        check("R2 first of pair addr", paddr_o, 24'h011000);
        form_i = 4'd2;
        @(negedge clk);
        req_i = 1'b0;
        check("R2 second of pair valid", {23'd0, valid_o}, 24'd1);
        check("R2 second of pair addr", paddr_o, 24'h020200);

        // R11 wrap gate
        ds_i = 16'hFFFF;
        a20_en_i = 1'b1;
        issue(2'd0, 4'd0, 2'd2, 1'b0, 1'b0, 2'd0, 16'hFFFF);
        check("R11 FFFF:FFFF wrap on", paddr_o, 24'h10FFEF);
        a20_en_i = 1'b0;
        issue(2'd0, 4'd0, 2'd2, 1'b0, 1'b0, 2'd0, 16'hFFFF);
        check("R11 FFFF:FFFF wrap off", paddr_o, 24'h00FFEF);
        a20_en_i = 1'b1;
        issue(2'd0, 4'd0, 2'd2, 1'b0, 1'b0, 2'd0, 16'h0010);
        check("R11 FFFF:0010 at 1MB", paddr_o, 24'h100000);
        cs_i = 16'hFFFF; ip_i = 16'h0010; a20_en_i = 1'b0;
        issue(2'd1, 4'd0, 2'd0, 1'b0, 1'b0, 2'd0, 16'h0000);
        check("R11 code fetch wraps to zero", paddr_o, 24'h000000);
        check("R11 valid on wrap", {23'd0, valid_o}, 24'd1);

        // R1 reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 addr cleared by reset", paddr_o, 24'd0);
        rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule